// File: doc/BRIEF.md
# Fall-Through Elastic FIFO Chain

This block is a first-in/first-out buffer made of a row of word stages rather than a RAM with read and write pointers. Each stage has its own occupancy marker, where 1 means full and 0 means vacant. A stage that is vacant takes the word from the stage just upstream of it when that stage is full, and the upstream stage then becomes vacant. Words therefore fall through toward the output end one stage per clock, and vacancies drift back toward the input end, with no external command. The whole chain runs on one system clock.

The input side sees a ready flag that is simply the first stage's vacancy, and it loads a word with a shift-in strobe. The output side sees a ready flag that is the last stage's marker, and it discards the oldest word with a shift-out strobe. The two sides may be strobed at unrelated rates, so the block can absorb a rate difference between a producer and a consumer. A separate output-enable gates the data outputs and is echoed as an output-drive flag in place of a tri-state pin. Units can be chained for more depth by wiring one unit's `dout_ready` to the next unit's `shift_in`, and the next unit's `din_ready` back to the first unit's `shift_out`. Units can be placed side by side for more width.

Top module: `elastic_fifo_chain`

## Requirements
- R1: `rst` is synchronous and active high. It empties every stage, so at the first falling edge after it is released `din_ready` is 1 and `dout_ready` is 0, whatever the chain held before.
- R2: `din_ready` is 1 exactly when the input-end stage is vacant. A rising edge with `shift_in` and `din_ready` both 1 captures `din`, and `din_ready` reads 0 after that edge.
- R3: A rising edge with `shift_in` at 1 while `din_ready` is 0 adds no word. The sequence of words later read out is exactly the sequence of accepted words.
- R4: A word accepted into an empty chain of `DEPTH` stages makes `dout_ready` rise at the `DEPTH`-th rising edge, counting the accepting edge as the first. `din_ready` is back at 1 after the second edge.
- R5: The chain holds at most `DEPTH` words. Words come out in the order they were accepted. With no reads and `shift_in` held at 1, exactly `DEPTH` words are accepted, after which `din_ready` stays 0.
- R6: A rising edge with `shift_out` and `dout_ready` both 1 removes the word shown on `dout`, and `dout_ready` reads 0 after that edge. When another word was waiting directly upstream, it shows up one edge later.
- R7: A rising edge with `shift_out` at 1 while `dout_ready` is 0 changes no marker. A word still moving down the chain at that time is neither lost nor duplicated.
- R8: While `dout_ready` is 1 and `shift_out` is 0, the word on `dout` stays constant.
- R9: `dout_oe` equals `out_en`. When `out_en` is 0, `dout` is all zeros. When `out_en` is 1, `dout` carries the output-end stage's word.
- R10: A shift-in and a shift-out may both act on the same rising edge, and each takes effect as if it were alone.
- R11: When a full chain loses its output word and nothing is written, the vacancy climbs one stage per edge. `din_ready` returns to 1 at the `DEPTH`-th rising edge, counting the removing edge as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; empties the chain |
| shift_in | input | 1 | Load `din` into the input-end stage when ready |
| din | input | WIDTH | Word to be stored |
| din_ready | output | 1 | Input-end stage is vacant |
| shift_out | input | 1 | Discard the output-end word when ready |
| dout_ready | output | 1 | Output-end stage holds a word |
| out_en | input | 1 | Enable for the data outputs |
| dout | output | WIDTH | Oldest word, zeros when `out_en` is 0 |
| dout_oe | output | 1 | Drive flag for `dout`, mirrors `out_en` |

## Verification
The bench builds the chain with `DEPTH` = 5 and `WIDTH` = 6. The short chain keeps the fall-through latency of R4 and the climbing vacancy of R11 down to a handful of edges, so both can be checked edge by edge. It also lets a fill with writes only, and a drain with reads only, each complete within a few cycles. The 6-bit width, which is not the usual 4, shows that no part of the data path is tied to one word size. The mixed run strobes the input on two cycles of three and the output on three cycles of four. That pattern reaches full, empty and partly filled states, and it produces edges where both sides act together.

// File: rtl/efc_pkg.sv
package efc_pkg;

  // What one stage does at the next rising edge.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,  // keep marker and word
    ACT_LOAD = 2'd1,  // vacant, upstream full: take upstream word
    ACT_HAND = 2'd2   // full, downstream takes it: become vacant
  } stage_act_e;

endpackage

// File: rtl/efc_stage.sv
module efc_stage
  import efc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_full,    // upstream marker (or write strobe at head)
  input  logic [WIDTH-1:0] up_data,
  input  logic             down_take,  // downstream vacant (or read strobe at tail)
  output logic             full,
  output logic [WIDTH-1:0] data
);

  stage_act_e act;

  always_comb begin
    if (!full && up_full)
      act = ACT_LOAD;
    else if (full && down_take)
      act = ACT_HAND;
    else
      act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst)
      full <= 1'b0;
    else begin
      case (act)
        ACT_LOAD: full <= 1'b1;
        ACT_HAND: full <= 1'b0;
        default:  full <= full;
      endcase
    end
  end

  // Word register carries no reset: its content only matters while full.
  always_ff @(posedge clk) begin
    if (act == ACT_LOAD)
      data <= up_data;
  end

endmodule

// File: rtl/efc_out_gate.sv
module efc_out_gate #(
  parameter int WIDTH = 4
) (
  input  logic             oe,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe
);

  // On-chip stand-in for a tri-state driver: data forced low, drive flag off.
  assign dout    = oe ? word : '0;
  assign dout_oe = oe;

endmodule

// File: rtl/elastic_fifo_chain.sv
module elastic_fifo_chain #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             din_ready,
  input  logic             shift_out,
  output logic             dout_ready,
  input  logic             out_en,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe
);

  localparam int HEAD = 0;
  localparam int TAIL = DEPTH - 1;

  logic [DEPTH-1:0] mark;
  logic [WIDTH-1:0] word [DEPTH];
  logic [WIDTH-1:0] tail_data;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic             up_f;
    logic [WIDTH-1:0] up_d;
    logic             dn_take;

    if (i == HEAD) begin : g_head
      assign up_f = shift_in;
      assign up_d = din;
    end else begin : g_link_up
      assign up_f = mark[i-1];
      assign up_d = word[i-1];
    end

    if (i == TAIL) begin : g_tail
      assign dn_take = shift_out;
    end else begin : g_link_dn
      assign dn_take = ~mark[i+1];
    end

    efc_stage #(.WIDTH(WIDTH)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .up_full   (up_f),
      .up_data   (up_d),
      .down_take (dn_take),
      .full      (mark[i]),
      .data      (word[i])
    );
  end

  assign tail_data  = word[TAIL];
  assign din_ready  = ~mark[HEAD];
  assign dout_ready = mark[TAIL];

  efc_out_gate #(.WIDTH(WIDTH)) u_out_gate (
    .oe      (out_en),
    .word    (tail_data),
    .dout    (dout),
    .dout_oe (dout_oe)
  );

endmodule

// File: rtl/efc_checker.sv
module efc_checker #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_in,
  input logic             din_ready,
  input logic             shift_out,
  input logic             dout_ready,
  input logic [WIDTH-1:0] tail_word
);

  localparam int CW = $clog2(DEPTH + 1) + 1;

  logic [CW-1:0] occ;
  logic          put, take;

  assign put  = shift_in && din_ready;
  assign take = shift_out && dout_ready;

  always_ff @(posedge clk) begin
    if (rst)
      occ <= '0;
    else
      occ <= occ + CW'(put) - CW'(take);
  end

  // R1: first cycle after reset shows an empty chain
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (din_ready && !dout_ready));

  // R2: accepting a word fills the head stage
  p_accept_fills_head_r2: assert property (@(posedge clk) disable iff (rst)
    put |=> !din_ready);

  // R3: a ready flag never claims a word that was never accepted
  p_ready_needs_word_r3: assert property (@(posedge clk) disable iff (rst)
    (dout_ready || !din_ready) |-> (occ != '0));

  // R5: never more than DEPTH words inside
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));

  // R6: removing the word empties the tail stage for one edge
  p_pop_clears_r6: assert property (@(posedge clk) disable iff (rst)
    take |=> !dout_ready);

  // R8: waiting output word is held
  p_word_held_r8: assert property (@(posedge clk) disable iff (rst)
    (dout_ready && !shift_out) |=> (dout_ready && $stable(tail_word)));

endmodule

bind elastic_fifo_chain efc_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_efc_checker (
  .clk        (clk),
  .rst        (rst),
  .shift_in   (shift_in),
  .din_ready  (din_ready),
  .shift_out  (shift_out),
  .dout_ready (dout_ready),
  .tail_word  (tail_data)
);

// File: tb/elastic_fifo_chain_bench.sv
`timescale 1ns/1ps
module elastic_fifo_chain_bench;

  localparam int W = 6;
  localparam int D = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         shift_in = 1'b0;
  logic         shift_out = 1'b0;
  logic         out_en = 1'b1;
  logic [W-1:0] din = '0;
  logic         din_ready, dout_ready, dout_oe;
  logic [W-1:0] dout;

  int n_chk = 0;
  int n_fail = 0;
  int both_cnt = 0;
  bit done = 1'b0;
  logic [W-1:0] sb [$];

  elastic_fifo_chain #(.WIDTH(W), .DEPTH(D)) u_elastic_fifo_chain (
    .clk(clk), .rst(rst), .shift_in(shift_in), .din(din), .din_ready(din_ready),
    .shift_out(shift_out), .dout_ready(dout_ready), .out_en(out_en),
    .dout(dout), .dout_oe(dout_oe)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Driver: sets the input side and records each word that will be accepted.
  task automatic drive_push(input logic si, input logic [W-1:0] d);
    shift_in = si;
    din      = d;
    if (si && din_ready) sb.push_back(d);
  endtask

  // Monitor: sets the output side and compares the word that will be removed.
  task automatic monitor_pop(input logic so, input string req);
    logic [W-1:0] exp;
    shift_out = so;
    if (so && dout_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, req, "word out with empty scoreboard", int'(dout), -1);
      end else begin
        exp = sb.pop_front();
        check(dout == exp, req, "dout order", int'(dout), int'(exp));
      end
    end
  endtask

  task automatic drain(input string req);
    for (int g = 0; g < 200 && sb.size() > 0; g++) begin
      monitor_pop(dout_ready, req);
      tick();
    end
    shift_out = 1'b0;
    check(sb.size() == 0, req, "scoreboard empty after drain", sb.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    rst = 1'b0;
    // R1: reset state
    check(din_ready == 1'b1, "R1", "din_ready after reset", din_ready, 1);
    check(dout_ready == 1'b0, "R1", "dout_ready after reset", dout_ready, 0);

    // R4 / R2: fall-through latency of a single word
    drive_push(1'b1, 6'h2A);
    tick();
    drive_push(1'b0, '0);
    check(din_ready == 1'b0, "R2", "din_ready after accept", din_ready, 0);
    check(dout_ready == 1'b0, "R4", "dout_ready after edge 1", dout_ready, 0);
    for (int k = 2; k <= D; k++) begin
      tick();
      if (k == 2) check(din_ready == 1'b1, "R4", "din_ready after edge 2", din_ready, 1);
      check(dout_ready == (k == D), "R4", $sformatf("dout_ready after edge %0d", k),
            dout_ready, int'(k == D));
    end

    // R8: held output word
    for (int k = 0; k < 3; k++) begin
      tick();
      check(dout_ready && dout == 6'h2A, "R8", "held word", int'(dout), 'h2A);
    end

    // R9: output enable
    out_en = 1'b0;
    #1;
    check(dout == '0, "R9", "dout when disabled", int'(dout), 0);
    check(dout_oe == 1'b0, "R9", "dout_oe when disabled", dout_oe, 0);
    out_en = 1'b1;
    #1;
    check(dout == 6'h2A, "R9", "dout when enabled", int'(dout), 'h2A);
    check(dout_oe == 1'b1, "R9", "dout_oe when enabled", dout_oe, 1);

    // R6: removing the only word
    tick();
    monitor_pop(1'b1, "R6");
    tick();
    shift_out = 1'b0;
    check(dout_ready == 1'b0, "R6", "dout_ready after removal", dout_ready, 0);

    // R7: read strobes while the word is still in transit
    drive_push(1'b1, 6'h15);
    tick();
    drive_push(1'b0, '0);
    tick();
    for (int k = 3; k <= D - 1; k++) begin
      check(dout_ready == 1'b0, "R7", "no word yet", dout_ready, 0);
      monitor_pop(1'b1, "R7");
      tick();
    end
    shift_out = 1'b0;
    tick();
    check(dout_ready == 1'b1, "R7", "word survived early strobes", dout_ready, 1);
    check(dout == 6'h15, "R7", "word value", int'(dout), 'h15);
    monitor_pop(1'b1, "R7");
    tick();
    shift_out = 1'b0;

    // R3 / R5: fill with writes only
    for (int i = 0; i < 40; i++) begin
      drive_push(1'b1, W'(i * 5 + 1));
      tick();
    end
    drive_push(1'b0, '0);
    check(din_ready == 1'b0, "R5", "din_ready when full", din_ready, 0);
    check(dout_ready == 1'b1, "R5", "dout_ready when full", dout_ready, 1);
    check(sb.size() == D, "R5", "words accepted", sb.size(), D);

    // R11: vacancy climbs back to the head
    monitor_pop(1'b1, "R11");
    tick();
    shift_out = 1'b0;
    check(din_ready == 1'b0, "R11", "din_ready after edge 1", din_ready, 0);
    check(dout_ready == 1'b0, "R6", "dout_ready after removal from full", dout_ready, 0);
    for (int k = 2; k <= D; k++) begin
      tick();
      if (k == 2) check(dout_ready == 1'b1, "R6", "next word arrives", dout_ready, 1);
      check(din_ready == (k == D), "R11", $sformatf("din_ready after edge %0d", k),
            din_ready, int'(k == D));
    end
    drain("R3");

    // R10: independent rates, both sides active
    for (int i = 0; i < 300; i++) begin
      logic si, so;
      si = (i % 3) != 2;
      so = (i % 4) != 0;
      if (si && din_ready && so && dout_ready) both_cnt++;
      drive_push(si, W'(i * 11 + 7));
      monitor_pop(so, "R10");
      tick();
    end
    drive_push(1'b0, '0);
    check(both_cnt > 0, "R10", "edges with both sides acting", both_cnt, 1);
    drain("R10");

    // R1: reset while words are inside
    drive_push(1'b1, 6'h33);
    tick();
    drive_push(1'b0, '0);
    repeat (D + 1) tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    sb.delete();
    check(din_ready == 1'b1, "R1", "din_ready after mid-run reset", din_ready, 1);
    check(dout_ready == 1'b0, "R1", "dout_ready after mid-run reset", dout_ready, 0);
    repeat (D + 1) tick();
    check(dout_ready == 1'b0, "R1", "no word reappears", dout_ready, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule